// File: doc/BRIEF.md
# Serial Data-Field Master Sequencer

This block is the master side of the data phase on a single-wire serial bus. A transfer begins with a start pulse and then takes bytes from a valid/ready source, one at a time. Each byte goes out as one data field of ten bit slots. The first eight slots carry the data bits, most significant first. The ninth slot carries an even parity bit. In the tenth slot the master releases the wire, and the slave may pull it low to accept the byte. The block moves forward one slot for each pulse on the slot strobe. Generating the strobe, the bit waveform, arbitration and the header fields are left to neighbouring logic.

In the normal addressed mode, a byte the slave does not accept is sent again without the source being involved. The transfer stops in one of two ways. It completes with a done pulse once the byte flagged as last has been accepted. Otherwise it gives up with a limit pulse when the shared attempt budget is used up while work remains. In broadcast mode the acknowledge slot is not examined: every byte is sent once and the block moves on.

Top module: `dfield_master`

## Requirements
- R1: Each field drives, one slot per strobe, the eight data bits from bit 7 down to bit 0 and then the parity bit. During these nine slots `bus_oe` is 1 and `bus_do` carries the bit.
- R2: The parity bit is the XOR of the eight data bits, so the nine driven bits hold an even number of ones.
- R3: In the tenth slot `bus_oe` is 0. The strobe that ends this slot samples `bus_sense`, and a 0 there means the byte was accepted.
- R4: In addressed mode, a refused byte is sent again from its first bit. No new source handshake takes place (`src_ready` stays 0).
- R5: The budget is loaded with BUDGET at start, and each field attempt (first send or resend) takes one unit. If the budget is zero when another attempt is needed, or when a further byte remains after an accepted non-last byte, `limit_hit` pulses for one cycle and the block returns to idle. A transfer of exactly BUDGET accepted bytes completes normally.
- R6: In broadcast mode, `bus_sense` in the acknowledge slot is ignored. Each byte is sent exactly once.
- R7: `xfer_done` pulses for one cycle in the cycle after the acknowledge-slot strobe of the last byte, provided that byte was accepted or broadcast mode is active. `xfer_done` and `limit_hit` never pulse together.
- R8: The bus outputs and the slot position change only on a strobe. Between strobes they hold.
- R9: After reset the block is idle: `busy`, `src_ready`, `bus_oe`, `bus_do`, `xfer_done` and `limit_hit` are all 0.
- R10: `start` and `bcast_mode` are sampled only while idle. A start pulse or a mode change during a transfer has no effect.
- R11: `src_ready` is 1 only while the block waits for the next byte. A byte is taken on a cycle where `src_valid` and `src_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| bcast_mode | input | 1 | 1 = broadcast, acknowledge ignored; sampled with start |
| src_valid | input | 1 | Source has a byte |
| src_data | input | DATA_W | Byte from the source |
| src_last | input | 1 | Byte is the final one of the transfer |
| src_ready | output | 1 | Block takes a byte this cycle if valid |
| slot_stb | input | 1 | One pulse per bit slot; ends the current slot |
| bus_oe | output | 1 | Master drives the wire |
| bus_do | output | 1 | Value driven while bus_oe is 1 |
| bus_sense | input | 1 | Level sensed on the wire |
| busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | One-cycle pulse: transfer completed |
| limit_hit | output | 1 | One-cycle pulse: attempt budget ran out |

## Verification
The bench looks for the places where the budget, the retry path and the acknowledge slot meet. It checks a refused byte that must go out again unchanged, a dead slave that drains all 32 attempts, exactly 32 accepted bytes that must still finish with done, and 33 bytes that must stop with one byte left unread. A design that decrements late or compares against the wrong boundary would pulse limit on the 32-byte run or send a 33rd field. A design that treats the acknowledge slot as driven, or that samples the mode at the wrong time, would keep retrying in broadcast mode or stop retrying in addressed mode. Strobe spacing and source stalls are varied so that any slot moving without a strobe shows up in the cycle-by-cycle comparison.

// File: rtl/dfm_pkg.sv
// Package: shared types for the data-field master sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dfm_pkg;

    // Sequencer phases: idle, waiting for a source byte, sending a field
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dfm_field_shifter.sv
// Module: dfm_field_shifter
// Holds the byte being sent and walks its field: DATA_W data bits MSB
// first, one even parity bit, then one released acknowledge slot.
// Assumes: load and retry are never asserted together; step is only
// honoured while 'sending' is high (the controller gates it).
module dfm_field_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              retry,
    input  logic              step,
    input  logic              sending,
    output logic              drv_en,
    output logic              drv_val,
    output logic              at_ack
);
    localparam int SLOTS = DATA_W + 2;
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(DATA_W + 1);

    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W:0]   par_chain;

    // XOR chain over the incoming byte, one stage per data bit
    assign par_chain[0] = 1'b0;
    for (genvar g = 0; g < DATA_W; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ load_data[g];
    end

    // Field state: capture on load, rewind on retry, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            idx_q   <= '0;
        end else if (load) begin
            byte_q  <= load_data;
            shift_q <= load_data;
            par_q   <= par_chain[DATA_W];
            idx_q   <= '0;
        end else if (retry) begin
            shift_q <= byte_q;
            idx_q   <= '0;
        end else if (step && sending && idx_q != ACK_IDX) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q < PAR_IDX) begin
                shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Output selection for the current slot
    always_comb begin
        at_ack  = (idx_q == ACK_IDX);
        drv_en  = sending && !at_ack;
        drv_val = 1'b0;
        if (drv_en) begin
            drv_val = (idx_q < PAR_IDX) ? shift_q[DATA_W-1] : par_q;
        end
    end

endmodule

// File: rtl/dfm_budget.sv
// Module: dfm_budget
// Down-counter of field attempts left in the current transfer.
// Assumes: consume is never raised while empty is high (the controller
// checks empty before starting an attempt).
module dfm_budget #(
    parameter int BUDGET = 32,
    parameter int CNT_W  = $clog2(BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             consume,
    output logic             empty,
    output logic [CNT_W-1:0] left
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BUDGET);

    logic [CNT_W-1:0] cnt_q;

    // Reload at transfer start, count down once per attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= FULL;
        end else if (consume && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty = (cnt_q == '0);
    assign left  = cnt_q;

endmodule

// File: rtl/dfm_seq_ctrl.sv
// Module: dfm_seq_ctrl
// Transfer sequencer: takes bytes from the source, decides after each
// acknowledge slot whether to finish, move on, resend or give up.
// Assumes: at_ack comes from the field shifter; bus_sense is already
// synchronised to clk.
module dfm_seq_ctrl
    import dfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bcast_mode,
    input  logic src_valid,
    input  logic src_last,
    input  logic slot_stb,
    input  logic bus_sense,
    input  logic at_ack,
    input  logic budget_empty,
    output logic src_ready,
    output logic load_byte,
    output logic retry_byte,
    output logic budget_load,
    output logic sending,
    output logic busy,
    output logic xfer_done,
    output logic limit_hit
);
    seq_state_t state_q, state_d;
    logic       bcast_q;
    logic       last_q;
    logic       done_q;
    logic       limit_q;
    logic       ack_edge;
    logic       accepted;
    logic       finish;
    logic       give_up;

    // Handshake and decision terms for the current cycle
    always_comb begin
        src_ready   = (state_q == ST_FETCH);
        load_byte   = src_ready && src_valid;
        sending     = (state_q == ST_SEND);
        busy        = (state_q != ST_IDLE);
        budget_load = (state_q == ST_IDLE) && start;
        ack_edge    = sending && slot_stb && at_ack;
        accepted    = bcast_q || !bus_sense;
        finish      = ack_edge && accepted && last_q;
        give_up     = ack_edge && !(accepted && last_q) && budget_empty;
        retry_byte  = ack_edge && !accepted && !budget_empty;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: if (load_byte) state_d = ST_SEND;
            ST_SEND: begin
                if (finish || give_up) begin
                    state_d = ST_IDLE;
                end else if (ack_edge && accepted) begin
                    state_d = ST_FETCH;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, sampled mode, last flag and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcast_q <= 1'b0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            limit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            limit_q <= give_up;
            if (budget_load) bcast_q <= bcast_mode;
            if (load_byte)   last_q  <= src_last;
        end
    end

    assign xfer_done = done_q;
    assign limit_hit = limit_q;

endmodule

// File: rtl/dfield_master.sv
// Module: dfield_master (top)
// Master-side data-field sequencer for a single-wire serial bus. Sends
// each source byte as data bits, even parity and a released acknowledge
// slot, resending refused bytes within a shared attempt budget.
// Assumes: slot_stb is a one-cycle pulse per bit slot generated by the
// bit-timing logic; bus_sense is synchronous to clk.
module dfield_master #(
    parameter int DATA_W = 8,
    parameter int BUDGET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bcast_mode,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_ready,
    input  logic              slot_stb,
    output logic              bus_oe,
    output logic              bus_do,
    input  logic              bus_sense,
    output logic              busy,
    output logic              xfer_done,
    output logic              limit_hit
);
    localparam int CNT_W = $clog2(BUDGET + 1);

    logic             load_byte;
    logic             retry_byte;
    logic             budget_load;
    logic             budget_empty;
    logic [CNT_W-1:0] budget_left;
    logic             sending;
    logic             at_ack;

    dfm_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .bcast_mode   (bcast_mode),
        .src_valid    (src_valid),
        .src_last     (src_last),
        .slot_stb     (slot_stb),
        .bus_sense    (bus_sense),
        .at_ack       (at_ack),
        .budget_empty (budget_empty),
        .src_ready    (src_ready),
        .load_byte    (load_byte),
        .retry_byte   (retry_byte),
        .budget_load  (budget_load),
        .sending      (sending),
        .busy         (busy),
        .xfer_done    (xfer_done),
        .limit_hit    (limit_hit)
    );

    dfm_field_shifter #(
        .DATA_W (DATA_W)
    ) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_byte),
        .load_data (src_data),
        .retry     (retry_byte),
        .step      (slot_stb),
        .sending   (sending),
        .drv_en    (bus_oe),
        .drv_val   (bus_do),
        .at_ack    (at_ack)
    );

    dfm_budget #(
        .BUDGET (BUDGET),
        .CNT_W  (CNT_W)
    ) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (budget_load),
        .consume (load_byte || retry_byte),
        .empty   (budget_empty),
        .left    (budget_left)
    );

endmodule

// File: rtl/dfield_master_chk.sv
// Module: dfield_master_chk
// Protocol checker bound to dfield_master; watches ports and the
// budget and slot state that separate submodules produce.
// Assumes: synchronous active-low reset.
module dfield_master_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_ready,
    input logic             slot_stb,
    input logic             bus_oe,
    input logic             bus_do,
    input logic             busy,
    input logic             xfer_done,
    input logic             limit_hit,
    input logic             at_ack,
    input logic [CNT_W-1:0] budget_left
);

    // R3: the master never drives the wire in the acknowledge slot
    assert_ack_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !src_ready && at_ack) |-> !bus_oe);

    // R5: limit only follows a decision made with an empty budget
    assert_limit_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |-> ($past(budget_left) == '0));

    // R7: done and limit are exclusive, and both end the transfer
    assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && limit_hit));
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || limit_hit) |-> !busy);

    // R8: bus outputs hold while sending without a strobe
    assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !src_ready && !slot_stb) |=> ($stable(bus_oe) && $stable(bus_do)));

    // R9: nothing is driven outside a transfer
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_oe && !bus_do && !src_ready));

    // R11: ready only while a transfer is active
    assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (busy && !bus_oe));

endmodule

bind dfield_master dfield_master_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_ready   (src_ready),
    .slot_stb    (slot_stb),
    .bus_oe      (bus_oe),
    .bus_do      (bus_do),
    .busy        (busy),
    .xfer_done   (xfer_done),
    .limit_hit   (limit_hit),
    .at_ack      (at_ack),
    .budget_left (budget_left)
);

// File: tb/dfield_master_test.sv
// Bench: behavioural reference model compared against the design on
// every clock, plus scenario checks on attempts, done and limit.
module dfield_master_test;
    localparam int BUD = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       bcast_mode = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic       slot_stb = 1'b0;
    logic       bus_oe;
    logic       bus_do;
    logic       bus_sense;
    logic       busy;
    logic       xfer_done;
    logic       limit_hit;
    logic       slave_pull = 1'b0;

    always #5 clk = ~clk;

    // Open-drain wire: low if the master drives 0 or the slave pulls
    assign bus_sense = ~((bus_oe & ~bus_do) | slave_pull);

    dfield_master #(.DATA_W(8), .BUDGET(BUD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bcast_mode(bcast_mode),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready), .slot_stb(slot_stb), .bus_oe(bus_oe),
        .bus_do(bus_do), .bus_sense(bus_sense), .busy(busy),
        .xfer_done(xfer_done), .limit_hit(limit_hit)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Stimulus knobs
    logic [7:0] q[$];
    bit src_gate = 1'b1;
    int stb_period = 3;
    int stb_cnt = 0;
    int nack_left = 0;
    bit slave_alive = 1'b1;

    // Observed counters (from design outputs)
    int ack_slots = 0;
    int done_cnt = 0;
    int limit_cnt = 0;

    // Reference model state
    int m_state = 0;   // 0 idle, 1 waiting for byte, 2 sending
    int m_idx = 0;     // slot 0..9
    int m_budget = 0;
    bit m_bc = 0;
    bit m_last = 0;
    bit [7:0] m_byte = 0;
    bit m_done = 0;
    bit m_limit = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Model, source, slave and strobe generation on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_budget = 0; m_bc = 0; m_last = 0;
            m_byte = 0; m_done = 0; m_limit = 0; stb_cnt = 0;
            slave_pull <= 1'b0;
            slot_stb <= 1'b0;
            src_valid <= 1'b0;
        end else begin
            if (slot_stb && busy && !src_ready && !bus_oe) ack_slots++;
            if (xfer_done) done_cnt++;
            if (limit_hit) limit_cnt++;
            m_done = 0;
            m_limit = 0;
            case (m_state)
                0: if (start) begin
                    m_bc = bcast_mode; m_budget = BUD; m_state = 1;
                end
                1: if (src_valid) begin
                    m_byte = src_data; m_last = src_last; m_idx = 0;
                    m_budget--; m_state = 2;
                    void'(q.pop_front());
                end
                default: if (slot_stb) begin
                    if (m_idx < 9) m_idx++;
                    else begin
                        bit ok;
                        ok = m_bc || !bus_sense;
                        if (nack_left > 0 && !m_bc) nack_left--;
                        if (ok && m_last) begin
                            m_done = 1; m_state = 0;
                        end else if (m_budget == 0) begin
                            m_limit = 1; m_state = 0;
                        end else if (ok) begin
                            m_state = 1;
                        end else begin
                            m_budget--; m_idx = 0;
                        end
                    end
                end
            endcase
            src_valid  <= src_gate && (q.size() > 0);
            src_data   <= (q.size() > 0) ? q[0] : 8'h00;
            src_last   <= (q.size() == 1);
            slave_pull <= (m_state == 2) && (m_idx == 9) && (nack_left == 0) && slave_alive;
            if (stb_cnt >= stb_period - 1) begin
                stb_cnt = 0; slot_stb <= 1'b1;
            end else begin
                stb_cnt++; slot_stb <= 1'b0;
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_oe, e_do;
            e_oe = (m_state == 2) && (m_idx < 9);
            e_do = e_oe ? ((m_idx < 8) ? m_byte[7 - m_idx] : ^m_byte) : 1'b0;
            chk("R10 busy", busy, m_state != 0);
            chk("R11 src_ready", src_ready, m_state == 1);
            chk("R1/R3/R8 bus_oe", bus_oe, e_oe);
            if (m_state == 2 && m_idx == 8) chk("R2 parity bit", bus_do, e_do);
            else chk("R1/R8 bus_do", bus_do, e_do);
            chk("R7 xfer_done", xfer_done, m_done);
            chk("R5 limit_hit", limit_hit, m_limit);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic clear_counts();
        ack_slots = 0; done_cnt = 0; limit_cnt = 0;
    endtask

    task automatic pulse_start(input bit bc);
        @(posedge clk); #1;
        bcast_mode = bc; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 40000) begin
            @(posedge clk); n++;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R7 transfer ends", busy, 0);
    endtask

    task automatic load_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) q.push_back(8'((seed + i * 37) ^ (i << 3)));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R9 busy after reset", busy, 0);
        chk("R9 src_ready after reset", src_ready, 0);
        chk("R9 bus_oe after reset", bus_oe, 0);
        chk("R9 bus_do after reset", bus_do, 0);
        chk("R9 xfer_done after reset", xfer_done, 0);
        chk("R9 limit_hit after reset", limit_hit, 0);
        rst_n = 1'b1;

        // T1: three bytes, slave accepts at once
        clear_counts(); stb_period = 3; slave_alive = 1; nack_left = 0;
        q.push_back(8'hA5); q.push_back(8'h01); q.push_back(8'hFE);
        pulse_start(1'b0); wait_idle();
        chk("R1 attempts normal", ack_slots, 3);
        chk("R7 done normal", done_cnt, 1);
        chk("R5 no limit normal", limit_cnt, 0);

        // T2: two refusals, then acceptance; source stalls between bytes
        clear_counts(); stb_period = 2; nack_left = 2; src_gate = 0;
        q.push_back(8'h3C); q.push_back(8'h80);
        pulse_start(1'b0);
        repeat (7) @(posedge clk); #1;
        chk("R11 ready while waiting", src_ready, 1);
        src_gate = 1;
        wait_idle();
        chk("R4 attempts with resend", ack_slots, 4);
        chk("R4 done after resend", done_cnt, 1);

        // T3: broadcast to a silent slave, every byte once
        clear_counts(); slave_alive = 0; stb_period = 1;
        load_bytes(3, 11);
        pulse_start(1'b1); wait_idle();
        chk("R6 broadcast attempts", ack_slots, 3);
        chk("R6 broadcast done", done_cnt, 1);
        chk("R6 broadcast no limit", limit_cnt, 0);

        // T4: addressed to a silent slave drains the budget
        clear_counts(); stb_period = 2;
        q.push_back(8'h5A);
        pulse_start(1'b0); wait_idle();
        chk("R5 budget attempts", ack_slots, BUD);
        chk("R5 limit pulse", limit_cnt, 1);
        chk("R5 no done on limit", done_cnt, 0);

        // T5: one byte more than the budget, all accepted
        clear_counts(); slave_alive = 1; stb_period = 1;
        load_bytes(BUD + 1, 5);
        pulse_start(1'b0); wait_idle();
        chk("R5 attempts over budget", ack_slots, BUD);
        chk("R5 limit with data left", limit_cnt, 1);
        chk("R5 byte left unread", q.size(), 1);
        q.delete();
        repeat (2) @(posedge clk); #1;

        // T6: exactly the budget, all accepted
        clear_counts();
        load_bytes(BUD, 77);
        pulse_start(1'b0); wait_idle();
        chk("R5 boundary done", done_cnt, 1);
        chk("R5 boundary no limit", limit_cnt, 0);

        // T7: start and mode change during a transfer are ignored
        clear_counts(); slave_alive = 0; stb_period = 1;
        q.push_back(8'hC3); q.push_back(8'h0F);
        pulse_start(1'b0);
        repeat (5) @(posedge clk); #1;
        bcast_mode = 1'b1; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();
        chk("R10 mode held at start", limit_cnt, 1);
        chk("R10 attempts unchanged", ack_slots, BUD);
        repeat (20) @(posedge clk); #1;
        chk("R10 no restart", busy, 0);
        q.delete();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule